// File: doc/BRIEF.md
# Dual-Processor Interrupt Delivery Router

This block serves a node that hosts two processors. It watches an 8-bit vector of pending interrupt sources and decides, for each source, which of the two processors hears about it and in what form. Software programs the routing through two 64-bit configuration registers. Each register describes four sources in 16-bit slices. A slice holds an enable for each processor, a 2-bit exception type and a 6-bit interrupt number.

A source is delivered when its pending bit rises. Type 0 means an external interrupt. For each enabled processor, the block sets the bit at the interrupt number in that processor's 64-bit request vector. Each processor clears its own bits with a write-1-to-clear acknowledge word. Any non-zero type is an exception event instead. It is queued per processor and reported on a one-cycle strobe that carries the type and the source index. When several queued events wait at once, they are reported lowest source first, one per cycle. The configuration registers keep their contents through reset. Software must write them before enabling any source.

Top module: `irq_route_dual`

## Requirements
- R1: A CSR write with `csr_addr_i`=0 stores `csr_wdata_i` as the routing word of sources 0..3, and address 1 does the same for sources 4..7. Source n uses bits [16*(n%4)+15 : 16*(n%4)]. `csr_rdata_o` shows the word at `csr_addr_i` combinationally, with every bit as written, unused bits included, and the word changes only on a write.
- R2: Reset leaves both routing words unchanged.
- R3: In a slice, bit 15 enables processor 0, bit 14 enables processor 1, bits 9:8 are the type and bits 5:0 are the number. A 0-to-1 change of `pend_i[n]` with type 0 sets bit [number] of `req0_o` (when bit 15 is set) and of `req1_o` (when bit 14 is set) at the next clock edge.
- R4: A processor whose enable bit is clear gets nothing from that source, neither a request bit nor a strobe. The other processor is unaffected.
- R5: A source that stays high is delivered once. It is delivered again only after it drops and rises.
- R6: Sources that rise in the same cycle are all delivered at the same edge, and their request bits are OR-ed into each vector.
- R7: A rise with a non-zero type leaves the request vector unchanged. One edge later, the enabled processor's `exc_vld_o[p]` is high for one cycle, with `exc_typeP_o` = type and `exc_srcP_o` = source index.
- R8: Several queued exception events are reported one per cycle, in ascending source order, independently for each processor.
- R9: A 1 in `ackP_i` clears that bit of `reqP_o` at the next edge and touches no other bit or processor. A set in the same cycle wins over the clear.
- R10: Reset empties both request vectors and both event queues and forgets the previous pending levels. A source held high while reset is released is delivered at the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | 8 | Pending level per interrupt source |
| csr_we_i | input | 1 | Routing register write strobe |
| csr_addr_i | input | 1 | Routing register select |
| csr_wdata_i | input | 64 | Routing register write data |
| csr_rdata_o | output | 64 | Routing register read data |
| ack0_i | input | 64 | Processor 0 write-1-to-clear acknowledge |
| ack1_i | input | 64 | Processor 1 write-1-to-clear acknowledge |
| req0_o | output | 64 | Processor 0 external interrupt request vector |
| req1_o | output | 64 | Processor 1 external interrupt request vector |
| exc_vld_o | output | 2 | Exception strobe, one bit per processor |
| exc_type0_o | output | 2 | Exception type for processor 0 |
| exc_type1_o | output | 2 | Exception type for processor 1 |
| exc_src0_o | output | 3 | Source index of processor 0 exception |
| exc_src1_o | output | 3 | Source index of processor 1 exception |

## Verification
A corrupted edge history shows up one edge after a rise as a missing or repeated request bit. Under a held level it also shows up in the cycles after an acknowledge. A wrong queue entry appears as a strobe with the wrong source or type, or as an out-of-order sequence, within as many cycles as there are queued events. A wrong routing slice appears at once on the read port and one edge later as a request bit on the wrong processor or at the wrong position. The sweeps cover every source against every enable pair and every type, so each slice offset and field position is reached.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
    localparam int NUM_CPU     = 2;
    localparam int SLICE_W     = 16;
    localparam int TYPE_W      = 2;
    localparam int NUM_W       = 6;
    localparam int EN_MSB      = 15;   // processor c enable at EN_MSB - c
    localparam int TYPE_LSB    = 8;
    localparam int NUM_LSB     = 0;
    localparam logic [TYPE_W-1:0] XT_EXTERNAL = '0;
endpackage

// File: rtl/irq_route_cfg.sv
`timescale 1ns/1ps
module irq_route_cfg
    import irq_route_pkg::*;
#(
    parameter int N_SRC       = 8,
    parameter int SRC_PER_REG = 4,
    localparam int N_REGS     = N_SRC / SRC_PER_REG,
    localparam int REG_W      = SLICE_W * SRC_PER_REG,
    localparam int ADDR_W     = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                                  clk,
    input  logic                                  we_i,
    input  logic [ADDR_W-1:0]                     addr_i,
    input  logic [REG_W-1:0]                      wdata_i,
    output logic [REG_W-1:0]                      rdata_o,
    output logic [N_SRC-1:0][NUM_CPU-1:0]         en_o,
    output logic [N_SRC-1:0][TYPE_W-1:0]          xtype_o,
    output logic [N_SRC-1:0][NUM_W-1:0]           num_o
);
    typedef struct packed {
        logic [N_REGS-1:0][REG_W-1:0] word;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int r = 0; r < N_REGS; r++) begin
            if (we_i && (int'(addr_i) == r)) begin
                cfg_d.word[r] = wdata_i;
            end
        end
        rdata_o = '0;
        for (int r = 0; r < N_REGS; r++) begin
            if (int'(addr_i) == r) begin
                rdata_o = cfg_q.word[r];
            end
        end
    end

    // Routing words are deliberately not reset.
    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_slice
        localparam int REG_IDX = s / SRC_PER_REG;
        localparam int BASE    = SLICE_W * (s % SRC_PER_REG);
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_en
            assign en_o[s][c] = cfg_q.word[REG_IDX][BASE + EN_MSB - c];
        end
        assign xtype_o[s] = cfg_q.word[REG_IDX][BASE + TYPE_LSB +: TYPE_W];
        assign num_o[s]   = cfg_q.word[REG_IDX][BASE + NUM_LSB +: NUM_W];
    end
endmodule

// File: rtl/irq_route_lane.sv
`timescale 1ns/1ps
module irq_route_lane
    import irq_route_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int VEC_W  = 64,
    localparam int SRC_W = $clog2(N_SRC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_SRC-1:0]                rise_i,
    input  logic [N_SRC-1:0]                en_i,
    input  logic [N_SRC-1:0][TYPE_W-1:0]    xtype_i,
    input  logic [N_SRC-1:0][NUM_W-1:0]     num_i,
    input  logic [VEC_W-1:0]                ack_i,
    output logic [VEC_W-1:0]                req_o,
    output logic                            exc_vld_o,
    output logic [TYPE_W-1:0]               exc_type_o,
    output logic [SRC_W-1:0]                exc_src_o
);
    typedef struct packed {
        logic [VEC_W-1:0]               req;
        logic [N_SRC-1:0]               qv;
        logic [N_SRC-1:0][TYPE_W-1:0]   qtype;
    } lane_state_t;

    lane_state_t      st_d, st_q;
    logic [VEC_W-1:0] set_w;
    logic [N_SRC-1:0] grant_w;

    always_comb begin
        st_d       = st_q;
        set_w      = '0;
        grant_w    = '0;
        exc_src_o  = '0;
        exc_type_o = '0;

        // Lowest queued source wins: scan downwards, last hit stays.
        for (int s = N_SRC - 1; s >= 0; s--) begin
            if (st_q.qv[s]) begin
                grant_w    = '0;
                grant_w[s] = 1'b1;
                exc_src_o  = SRC_W'(s);
                exc_type_o = st_q.qtype[s];
            end
        end
        exc_vld_o = |st_q.qv;

        st_d.qv = st_q.qv & ~grant_w;

        for (int s = 0; s < N_SRC; s++) begin
            if (rise_i[s] && en_i[s]) begin
                if (xtype_i[s] == XT_EXTERNAL) begin
                    set_w[num_i[s]] = 1'b1;
                end else begin
                    st_d.qv[s]    = 1'b1;
                    st_d.qtype[s] = xtype_i[s];
                end
            end
        end

        // A new set outranks an acknowledge in the same cycle.
        st_d.req = (st_q.req & ~ack_i) | set_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;
endmodule

// File: rtl/irq_route_dual.sv
`timescale 1ns/1ps
module irq_route_dual
    import irq_route_pkg::*;
#(
    parameter int N_SRC       = 8,
    parameter int SRC_PER_REG = 4,
    parameter int VEC_W       = 64,
    localparam int N_REGS     = N_SRC / SRC_PER_REG,
    localparam int REG_W      = SLICE_W * SRC_PER_REG,
    localparam int ADDR_W     = (N_REGS > 1) ? $clog2(N_REGS) : 1,
    localparam int SRC_W      = $clog2(N_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   pend_i,
    input  logic               csr_we_i,
    input  logic [ADDR_W-1:0]  csr_addr_i,
    input  logic [REG_W-1:0]   csr_wdata_i,
    output logic [REG_W-1:0]   csr_rdata_o,
    input  logic [VEC_W-1:0]   ack0_i,
    input  logic [VEC_W-1:0]   ack1_i,
    output logic [VEC_W-1:0]   req0_o,
    output logic [VEC_W-1:0]   req1_o,
    output logic [NUM_CPU-1:0] exc_vld_o,
    output logic [TYPE_W-1:0]  exc_type0_o,
    output logic [TYPE_W-1:0]  exc_type1_o,
    output logic [SRC_W-1:0]   exc_src0_o,
    output logic [SRC_W-1:0]   exc_src1_o
);
    typedef struct packed {
        logic [N_SRC-1:0] pend;
    } edge_state_t;

    edge_state_t edge_d, edge_q;
    logic [N_SRC-1:0] rise_w;

    logic [N_SRC-1:0][NUM_CPU-1:0] en_w;
    logic [N_SRC-1:0][TYPE_W-1:0]  xtype_w;
    logic [N_SRC-1:0][NUM_W-1:0]   num_w;

    logic [NUM_CPU-1:0][VEC_W-1:0]  ack_w;
    logic [NUM_CPU-1:0][VEC_W-1:0]  req_w;
    logic [NUM_CPU-1:0][TYPE_W-1:0] type_w;
    logic [NUM_CPU-1:0][SRC_W-1:0]  src_w;

    always_comb begin
        edge_d      = edge_q;
        edge_d.pend = pend_i;
        rise_w      = pend_i & ~edge_q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= edge_d;
        end
    end

    irq_route_cfg #(
        .N_SRC       (N_SRC),
        .SRC_PER_REG (SRC_PER_REG)
    ) i_cfg (
        .clk     (clk),
        .we_i    (csr_we_i),
        .addr_i  (csr_addr_i),
        .wdata_i (csr_wdata_i),
        .rdata_o (csr_rdata_o),
        .en_o    (en_w),
        .xtype_o (xtype_w),
        .num_o   (num_w)
    );

    assign ack_w[0] = ack0_i;
    assign ack_w[1] = ack1_i;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_lane
        logic [N_SRC-1:0] lane_en;
        for (genvar s = 0; s < N_SRC; s++) begin : g_en
            assign lane_en[s] = en_w[s][c];
        end
        irq_route_lane #(
            .N_SRC (N_SRC),
            .VEC_W (VEC_W)
        ) i_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .rise_i     (rise_w),
            .en_i       (lane_en),
            .xtype_i    (xtype_w),
            .num_i      (num_w),
            .ack_i      (ack_w[c]),
            .req_o      (req_w[c]),
            .exc_vld_o  (exc_vld_o[c]),
            .exc_type_o (type_w[c]),
            .exc_src_o  (src_w[c])
        );
    end

    assign req0_o      = req_w[0];
    assign req1_o      = req_w[1];
    assign exc_type0_o = type_w[0];
    assign exc_type1_o = type_w[1];
    assign exc_src0_o  = src_w[0];
    assign exc_src1_o  = src_w[1];
endmodule

// File: rtl/irq_route_dual_chk.sv
`timescale 1ns/1ps
module irq_route_dual_chk #(
    parameter int N_SRC  = 8,
    parameter int ADDR_W = 1,
    parameter int REG_W  = 64,
    parameter int VEC_W  = 64,
    parameter int SRC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  pend_i,
    input logic              csr_we_i,
    input logic [ADDR_W-1:0] csr_addr_i,
    input logic [REG_W-1:0]  csr_wdata_i,
    input logic [REG_W-1:0]  csr_rdata_o,
    input logic [VEC_W-1:0]  ack0_i,
    input logic [VEC_W-1:0]  ack1_i,
    input logic [VEC_W-1:0]  req0_o,
    input logic [VEC_W-1:0]  req1_o,
    input logic [1:0]        exc_vld_o,
    input logic [1:0]        exc_type0_o,
    input logic [1:0]        exc_type1_o,
    input logic [SRC_W-1:0]  exc_src0_o,
    input logic [SRC_W-1:0]  exc_src1_o
);
    logic rst_seen_q = 1'b0;

    always @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    always @(negedge clk) begin
        if (rst_seen_q) begin
            assert_reset_clears_R10: assert (req0_o == '0 && req1_o == '0 && exc_vld_o == '0)
                else $error("outputs not cleared after reset edge");
        end
    end

    assert_cfg_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we_i |=> (!$stable(csr_addr_i) || $stable(csr_rdata_o)));

    assert_req_rise_needs_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((req0_o | req1_o) & ~($past(req0_o) | $past(req1_o))) == '0) || ($past(pend_i) != '0));

    assert_exc_type_nonzero_cpu0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_vld_o[0] |-> (exc_type0_o != 2'd0));

    assert_exc_type_nonzero_cpu1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_vld_o[1] |-> (exc_type1_o != 2'd0));

    assert_strobe_advances_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_vld_o[0] |=> (!exc_vld_o[0] || (exc_src0_o != $past(exc_src0_o)) || ($past(pend_i) != '0)));

    assert_ack_only_clears_cpu0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(req0_o) & ~req0_o & ~$past(ack0_i)) == '0));

    assert_ack_only_clears_cpu1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(req1_o) & ~req1_o & ~$past(ack1_i)) == '0));
endmodule

bind irq_route_dual irq_route_dual_chk #(
    .N_SRC  (N_SRC),
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .VEC_W  (VEC_W),
    .SRC_W  (SRC_W)
) i_chk (.*);

// File: tb/test_irq_route_dual.sv
`timescale 1ns/1ps
module test_irq_route_dual;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  pend;
    logic        we;
    logic [0:0]  addr;
    logic [63:0] wdata;
    logic [63:0] rdata;
    logic [63:0] ack0, ack1, req0, req1;
    logic [1:0]  vld, type0, type1;
    logic [2:0]  src0, src1;

    int errs = 0;
    int checks = 0;
    logic [63:0] shadow [2];

    always #10 clk = ~clk;

    irq_route_dual i_irq_route_dual (
        .clk(clk), .rst_n(rst_n), .pend_i(pend),
        .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
        .ack0_i(ack0), .ack1_i(ack1), .req0_o(req0), .req1_o(req1),
        .exc_vld_o(vld), .exc_type0_o(type0), .exc_type1_o(type1),
        .exc_src0_o(src0), .exc_src1_o(src1)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic csr_wr(input int a, input logic [63:0] d);
        @(negedge clk);
        we = 1'b1; addr = a[0]; wdata = d;
        @(posedge clk);
        #1 we = 1'b0;
        shadow[a] = d;
    endtask

    task automatic set_slice(input int s, input bit e0, input bit e1,
                             input logic [1:0] t, input logic [5:0] n);
        logic [63:0] v;
        v = shadow[s / 4];
        v[16 * (s % 4) +: 16] = {e0, e1, 4'h0, t, 2'b00, n};
        csr_wr(s / 4, v);
    endtask

    task automatic pulse(input logic [7:0] b);
        @(negedge clk);
        pend = b;
        @(posedge clk);
        #1 pend = '0;
    endtask

    task automatic ack_all();
        @(negedge clk);
        ack0 = '1; ack1 = '1;
        @(posedge clk);
        #1 ack0 = '0; ack1 = '0;
    endtask

    initial begin
        #(20 * 100000);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pend = '0; we = 1'b0; addr = '0; wdata = '0; ack0 = '0; ack1 = '0;
        idle(3);
        chk("R10 reset req0", req0, 64'd0);
        chk("R10 reset req1", req1, 64'd0);
        chk("R10 reset strobes", {62'd0, vld}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: write/read back both words, every bit including unused ones
        csr_wr(0, 64'h0123_4567_89AB_CDEF);
        csr_wr(1, 64'hFEDC_BA98_7654_3210);
        @(negedge clk); addr = 1'b0; #1 chk("R1 read word0", rdata, 64'h0123_4567_89AB_CDEF);
        addr = 1'b1; #1 chk("R1 read word1", rdata, 64'hFEDC_BA98_7654_3210);
        csr_wr(0, 64'd0);
        csr_wr(1, 64'd0);
        @(negedge clk); addr = 1'b0; #1 chk("R1 cleared word0", rdata, 64'd0);
        ack_all();

        // R3/R4: every source against every enable pair, type 0
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 4; c++) begin
                logic [5:0] n;
                n = 6'((s * 9 + c * 17 + 5) % 64);
                set_slice(s, c[0], c[1], 2'd0, n);
                pulse(8'(1 << s));
                chk($sformatf("R3 R4 src%0d en%0d req0", s, c), req0, c[0] ? (64'd1 << n) : 64'd0);
                chk($sformatf("R3 R4 src%0d en%0d req1", s, c), req1, c[1] ? (64'd1 << n) : 64'd0);
                chk($sformatf("R4 src%0d no strobe", s), {62'd0, vld}, 64'd0);
                ack_all();
                set_slice(s, 1'b0, 1'b0, 2'd0, 6'd0);
            end
        end

        // R7: every source with each non-zero type
        for (int s = 0; s < 8; s++) begin
            for (int t = 1; t < 4; t++) begin
                set_slice(s, 1'b1, (t == 2), 2'(t), 6'(s));
                pulse(8'(1 << s));
                chk($sformatf("R7 src%0d t%0d vld", s, t), {62'd0, vld}, (t == 2) ? 64'd3 : 64'd1);
                chk($sformatf("R7 src%0d t%0d type0", s, t), {62'd0, type0}, 64'(t));
                chk($sformatf("R7 src%0d t%0d src0", s, t), {61'd0, src0}, 64'(s));
                if (t == 2) chk($sformatf("R7 src%0d src1", s), {61'd0, src1}, 64'(s));
                chk($sformatf("R7 src%0d req untouched", s), req0 | req1, 64'd0);
                idle(1);
                chk($sformatf("R7 src%0d one-cycle strobe", s), {62'd0, vld}, 64'd0);
            end
            set_slice(s, 1'b0, 1'b0, 2'd0, 6'd0);
        end

        // R8: ordering, two patterns, both processors enabled
        for (int s = 0; s < 8; s++) set_slice(s, 1'b1, 1'b1, 2'((s % 3) + 1), 6'd0);
        for (int p = 0; p < 2; p++) begin
            logic [7:0] pat;
            pat = (p == 0) ? 8'b1011_0101 : 8'b0100_1010;
            pulse(pat);
            for (int s = 0; s < 8; s++) begin
                if (pat[s]) begin
                    chk($sformatf("R8 pat%0d vld src%0d", p, s), {62'd0, vld}, 64'd3);
                    chk($sformatf("R8 pat%0d order cpu0", p), {61'd0, src0}, 64'(s));
                    chk($sformatf("R8 pat%0d order cpu1", p), {61'd0, src1}, 64'(s));
                    chk($sformatf("R8 pat%0d type", p), {62'd0, type0}, 64'((s % 3) + 1));
                    idle(1);
                end
            end
            chk($sformatf("R8 pat%0d drained", p), {62'd0, vld}, 64'd0);
        end
        csr_wr(0, 64'd0);
        csr_wr(1, 64'd0);

        // R6: simultaneous rises OR together
        set_slice(0, 1'b1, 1'b1, 2'd0, 6'd40);
        set_slice(1, 1'b1, 1'b0, 2'd0, 6'd2);
        set_slice(3, 1'b1, 1'b1, 2'd0, 6'd40);
        set_slice(6, 1'b0, 1'b1, 2'd0, 6'd63);
        pulse(8'b0100_1011);
        chk("R6 merged req0", req0, (64'd1 << 2) | (64'd1 << 40));
        chk("R6 merged req1", req1, (64'd1 << 40) | (64'd1 << 63));

        // R9: partial acknowledge, then set beats clear
        @(negedge clk); ack0 = 64'd1 << 40;
        @(posedge clk); #1 ack0 = '0;
        chk("R9 ack0 partial", req0, 64'd1 << 2);
        chk("R9 ack0 leaves cpu1", req1, (64'd1 << 40) | (64'd1 << 63));
        @(negedge clk); pend = 8'b0000_0010; ack0 = 64'd1 << 2;
        @(posedge clk); #1 pend = '0; ack0 = '0;
        chk("R9 set wins over clear", req0, 64'd1 << 2);
        ack_all();
        chk("R9 all cleared", req0 | req1, 64'd0);
        csr_wr(0, 64'd0);
        csr_wr(1, 64'd0);

        // R5: held level delivers once
        set_slice(2, 1'b1, 1'b0, 2'd0, 6'd10);
        @(negedge clk); pend = 8'b0000_0100;
        idle(1);
        chk("R5 first delivery", req0, 64'd1 << 10);
        @(negedge clk); ack0 = 64'd1 << 10;
        @(posedge clk); #1 ack0 = '0;
        idle(3);
        chk("R5 held no redelivery", req0, 64'd0);
        @(negedge clk); pend = '0;
        idle(1);
        @(negedge clk); pend = 8'b0000_0100;
        idle(1);
        chk("R5 re-rise delivers", req0, 64'd1 << 10);
        @(negedge clk); pend = '0;
        ack_all();

        // R10/R2: reset clears state, keeps routing, forgets history
        set_slice(7, 1'b1, 1'b0, 2'd0, 6'd33);
        set_slice(4, 1'b1, 1'b1, 2'd3, 6'd0);
        pulse(8'b1001_0000);
        chk("R10 pre-reset req", req0, 64'd1 << 33);
        @(negedge clk); pend = 8'b1000_0000; rst_n = 1'b0;
        idle(2);
        chk("R10 req0 cleared", req0, 64'd0);
        chk("R10 queue cleared", {62'd0, vld}, 64'd0);
        @(negedge clk); addr = 1'b0; #1 chk("R2 word0 kept", rdata, shadow[0]);
        addr = 1'b1; #1 chk("R2 word1 kept", rdata, shadow[1]);
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        chk("R10 held source after reset", req0, 64'd1 << 33);
        @(negedge clk); pend = '0;
        ack_all();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule